// File: doc/BRIEF.md
# I2C Write Master with NACK Lock

This block is an I2C master that only writes. Software, or a DMA engine, loads bytes into a one-entry holding register. Control, target address and interrupt mask are set through a small register write port. A status vector is always visible, and a read strobe acknowledges it. When the bus is idle and a byte is waiting, the block sends a START, then the 7-bit target address with the write bit, then the byte. More bytes go out in the same frame as long as each one arrives before the acknowledge slot of the byte in flight ends. Otherwise the block ends the frame with a STOP.

A DMA request is raised whenever the holding register is empty. A target that is busy answers with NACK. The block then reports NACK, frame-complete and holding-register-empty together, throws away the byte it was holding, and ends the frame with a STOP. The DMA request that follows would normally trigger a new and unwanted frame. With the lock enable set, the transmitter stops after the NACK instead. A byte written after that stays in the holding register until software issues a lock-clear command, and only then is it sent.

Both bus lines are open-drain outputs, and the block drives a line low by asserting its output enable. SDA is read back so that ACK can be sampled. One quarter of an SCL period lasts `QTR_DIV` clock cycles.

Top module: `i2c_txlock_master`

## Requirements
- R1: After reset the status reads txrdy=1, txcomp=1, nack=0 (status bit 0 txrdy, bit 1 txcomp, bit 2 nack), `dma_req_o` is 1, `irq_o` is 0 and both line enables are 0.
- R2: A byte written to the holding register (register address 2) while the engine is idle and not locked starts a frame: START, then the address byte {target address from register address 1 bits 6:0, 0}, then the data byte, each sent MSB first.
- R3: txrdy and `dma_req_o` drop once a byte is written to the holding register. They rise again when the byte moves into the shifter, which happens at the end of the previous byte's acknowledge slot and so before that frame's STOP.
- R4: A byte written before the acknowledge slot of the current byte ends is sent in the same frame. If the holding register is empty at that point, the frame ends with a STOP, and a later byte opens a new frame.
- R5: txcomp is cleared when a frame starts and is set once its STOP has completed.
- R6: A NACK sets nack, txcomp and txrdy in the same cycle, discards the byte waiting in the holding register, and ends the frame with a STOP.
- R7: With lock enable off (control register, address 0, bit 0), a byte written after a NACK starts a new frame as soon as the STOP has completed.
- R8: With lock enable on, a NACK locks the transmitter. A byte written while locked is held, with txrdy=0 and no START. Writing the control register with bit 1 (lock clear) set unlocks it, and the held byte is then sent.
- R9: A pulse on `stat_rd_i` clears nack. If a NACK and the read fall in the same cycle, nack stays set. A stale NACK that has been read no longer raises an interrupt when its mask bit is enabled again.
- R10: `irq_o` is high exactly when some status bit is set and its mask bit (register address 3, same bit positions as the status) is set.
- R11: While SCL is high, SDA changes only in a START or a STOP. Consecutive SCL rising edges within a frame are 4*QTR_DIV cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 control, 1 target address, 2 holding register, 3 interrupt mask |
| reg_wdata_i | input | DATA_W | Register write data |
| stat_rd_i | input | 1 | Status read strobe, clears nack |
| stat_o | output | 3 | Status: bit 0 txrdy, bit 1 txcomp, bit 2 nack |
| dma_req_o | output | 1 | DMA request, high while the holding register is empty |
| irq_o | output | 1 | Interrupt line |
| scl_oe_o | output | 1 | Pulls SCL low when high |
| sda_oe_o | output | 1 | Pulls SDA low when high |
| sda_i | input | 1 | SDA line level |

## Verification
The assertions rely on four things. There is a single master on the bus. The target never stretches SCL. The target drives SDA only inside the acknowledge slot. Nothing writes the holding register while it is full, so no write is silently dropped. The bench target model stays inside these limits: it pulls SDA low from the SCL fall that ends the eighth bit until the SCL fall that ends the ninth, and it sends NACK only on address bytes, for a number of attempts the bench picks. The bench writes the holding register only after it has seen `dma_req_o` high, which is how a DMA engine paces itself. It also pulses the lock clear only after the lock has taken hold.

// File: rtl/i2c_wm_pkg.sv
package i2c_wm_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_BIT, ST_ACK, ST_STOP} eng_st_e;

  localparam int unsigned STAT_W      = 3;
  localparam int unsigned STAT_TXRDY  = 0;
  localparam int unsigned STAT_TXCOMP = 1;
  localparam int unsigned STAT_NACK   = 2;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_SADDR = 2'd1;
  localparam logic [1:0] ADDR_THR   = 2'd2;
  localparam logic [1:0] ADDR_IMR   = 2'd3;

  localparam int unsigned CTRL_LOCK_EN  = 0;
  localparam int unsigned CTRL_LOCK_CLR = 1;
endpackage

// File: rtl/i2c_wm_tick.sv
module i2c_wm_tick #(
  parameter int unsigned QTR_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  generate
    if (QTR_DIV <= 1) begin : g_full_rate
      assign tick_o = en_i;
    end else begin : g_div
      localparam int unsigned CW = $clog2(QTR_DIV);
      localparam logic [CW-1:0] CNT_MAX = CW'(QTR_DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        cnt_q <= '0;
        else if (!en_i || cnt_q == CNT_MAX) cnt_q <= '0;
        else                                cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = en_i && (cnt_q == CNT_MAX);
    end
  endgenerate
endmodule

// File: rtl/i2c_wm_regs.sv
module i2c_wm_regs
  import i2c_wm_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              stat_rd_i,
  input  logic              ev_start_i,
  input  logic              ev_load_i,
  input  logic              ev_nack_i,
  input  logic              ev_done_i,
  output logic              thr_full_o,
  output logic [DATA_W-1:0] thr_data_o,
  output logic [DATA_W-2:0] saddr_o,
  output logic              locked_o,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o
);
  logic              thr_full_q, lock_en_q, locked_q, nack_q, txcomp_q;
  logic [DATA_W-1:0] thr_data_q;
  logic [DATA_W-2:0] saddr_q;
  logic [STAT_W-1:0] imr_q, stat_w;
  logic              wr_ctrl, wr_saddr, wr_thr, wr_imr;

  assign wr_ctrl  = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign wr_saddr = reg_we_i && (reg_addr_i == ADDR_SADDR);
  assign wr_thr   = reg_we_i && (reg_addr_i == ADDR_THR);
  assign wr_imr   = reg_we_i && (reg_addr_i == ADDR_IMR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_full_q <= 1'b0;
      thr_data_q <= '0;
      saddr_q    <= '0;
      imr_q      <= '0;
      lock_en_q  <= 1'b0;
      locked_q   <= 1'b0;
      nack_q     <= 1'b0;
      txcomp_q   <= 1'b1;
    end else begin
      if (wr_saddr) saddr_q <= reg_wdata_i[DATA_W-2:0];
      if (wr_imr)   imr_q   <= reg_wdata_i[STAT_W-1:0];
      if (wr_ctrl)  lock_en_q <= reg_wdata_i[CTRL_LOCK_EN];
      // a write into a full holding register is dropped; a fresh write survives a flush
      if (wr_thr && !thr_full_q) begin
        thr_full_q <= 1'b1;
        thr_data_q <= reg_wdata_i;
      end else if (ev_load_i || ev_nack_i) begin
        thr_full_q <= 1'b0;
      end
      if (ev_nack_i)      nack_q <= 1'b1;
      else if (stat_rd_i) nack_q <= 1'b0;
      if (ev_nack_i || ev_done_i) txcomp_q <= 1'b1;
      else if (ev_start_i)        txcomp_q <= 1'b0;
      if (ev_nack_i && lock_en_q)                  locked_q <= 1'b1;
      else if (wr_ctrl && reg_wdata_i[CTRL_LOCK_CLR]) locked_q <= 1'b0;
    end
  end

  assign stat_w[STAT_TXRDY]  = !thr_full_q;
  assign stat_w[STAT_TXCOMP] = txcomp_q;
  assign stat_w[STAT_NACK]   = nack_q;

  assign stat_o     = stat_w;
  assign irq_o      = |(stat_w & imr_q);
  assign thr_full_o = thr_full_q;
  assign thr_data_o = thr_data_q;
  assign saddr_o    = saddr_q;
  assign locked_o   = locked_q;

  p_load_frees_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_load_i |=> !thr_full_q);

  p_start_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_start_i |=> !txcomp_q);

  p_nack_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_nack_i && !wr_thr) |=> (nack_q && txcomp_q && !thr_full_q));

  p_read_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !ev_nack_i) |=> !nack_q);

  p_nack_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_nack_i |=> nack_q);

  p_irq_nack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nack_q && imr_q[STAT_NACK]) |-> irq_o);

  p_irq_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imr_q == '0) |-> !irq_o);
endmodule

// File: rtl/i2c_wm_engine.sv
module i2c_wm_engine
  import i2c_wm_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned QTR_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              thr_full_i,
  input  logic [DATA_W-1:0] thr_data_i,
  input  logic [DATA_W-2:0] saddr_i,
  input  logic              locked_i,
  input  logic              sda_i,
  output logic              ev_start_o,
  output logic              ev_load_o,
  output logic              ev_nack_o,
  output logic              ev_done_o,
  output logic              scl_low_o,
  output logic              sda_low_o
);
  localparam int unsigned BCW = $clog2(DATA_W);
  localparam logic [BCW-1:0] BIT_TOP = BCW'(DATA_W - 1);

  eng_st_e           st_q, st_d;
  logic [1:0]        qph_q, qph_d;
  logic [BCW-1:0]    bit_q, bit_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              sda_hi_q, sda_hi_d;
  logic              scl_low_q, scl_low_d, sda_low_q, sda_low_d;
  logic              tick;

  i2c_wm_tick #(.QTR_DIV(QTR_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (st_q != ST_IDLE),
    .tick_o(tick)
  );

  // each bit is four quarters; line levels are registered for the quarter being entered
  always_comb begin
    st_d       = st_q;
    qph_d      = qph_q;
    bit_d      = bit_q;
    sh_d       = sh_q;
    sda_hi_d   = sda_hi_q;
    scl_low_d  = scl_low_q;
    sda_low_d  = sda_low_q;
    ev_start_o = 1'b0;
    ev_load_o  = 1'b0;
    ev_nack_o  = 1'b0;
    ev_done_o  = 1'b0;
    if (st_q == ST_IDLE) begin
      if (thr_full_i && !locked_i) begin
        st_d       = ST_START;
        qph_d      = 2'd0;
        bit_d      = BIT_TOP;
        sh_d       = {saddr_i, 1'b0};
        ev_start_o = 1'b1;
      end
    end else if (tick) begin
      qph_d = qph_q + 2'd1;
      unique case (st_q)
        ST_START: begin
          case (qph_q)
            2'd0:    sda_low_d = 1'b1;
            2'd2:    scl_low_d = 1'b1;
            2'd3:    st_d = ST_BIT;
            default: ;
          endcase
        end
        ST_BIT: begin
          case (qph_q)
            2'd0: sda_low_d = !sh_q[DATA_W-1];
            2'd1: scl_low_d = 1'b0;
            2'd3: begin
              scl_low_d = 1'b1;
              sh_d      = {sh_q[DATA_W-2:0], 1'b0};
              if (bit_q == '0) st_d = ST_ACK;
              else             bit_d = bit_q - 1'b1;
            end
            default: ;
          endcase
        end
        ST_ACK: begin
          case (qph_q)
            2'd0: sda_low_d = 1'b0;
            2'd1: scl_low_d = 1'b0;
            2'd2: sda_hi_d  = sda_i;
            2'd3: begin
              scl_low_d = 1'b1;
              if (sda_hi_q) begin
                ev_nack_o = 1'b1;
                st_d      = ST_STOP;
              end else if (thr_full_i) begin
                ev_load_o = 1'b1;
                sh_d      = thr_data_i;
                bit_d     = BIT_TOP;
                st_d      = ST_BIT;
              end else begin
                st_d = ST_STOP;
              end
            end
            default: ;
          endcase
        end
        ST_STOP: begin
          case (qph_q)
            2'd0: sda_low_d = 1'b1;
            2'd1: scl_low_d = 1'b0;
            2'd2: sda_low_d = 1'b0;
            2'd3: begin
              st_d      = ST_IDLE;
              ev_done_o = 1'b1;
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      qph_q     <= 2'd0;
      bit_q     <= '0;
      sh_q      <= '0;
      sda_hi_q  <= 1'b1;
      scl_low_q <= 1'b0;
      sda_low_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      qph_q     <= qph_d;
      bit_q     <= bit_d;
      sh_q      <= sh_d;
      sda_hi_q  <= sda_hi_d;
      scl_low_q <= scl_low_d;
      sda_low_q <= sda_low_d;
    end
  end

  assign scl_low_o = scl_low_q;
  assign sda_low_o = sda_low_q;

  p_sda_edges_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_low_q && !$past(scl_low_q) && (sda_low_q != $past(sda_low_q)))
      |-> (st_q == ST_START || st_q == ST_STOP));

  p_locked_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && locked_i) |=> (st_q == ST_IDLE));

  p_idle_released_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> (!scl_low_q && !sda_low_q));
endmodule

// File: rtl/i2c_txlock_master.sv
module i2c_txlock_master
  import i2c_wm_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned QTR_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              stat_rd_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              dma_req_o,
  output logic              irq_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic              sda_i
);
  localparam int unsigned ADDR_W = DATA_W - 1;

  logic              thr_full, locked;
  logic [DATA_W-1:0] thr_data;
  logic [ADDR_W-1:0] saddr;
  logic              ev_start, ev_load, ev_nack, ev_done;
  logic [STAT_W-1:0] stat;

  i2c_wm_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .stat_rd_i  (stat_rd_i),
    .ev_start_i (ev_start),
    .ev_load_i  (ev_load),
    .ev_nack_i  (ev_nack),
    .ev_done_i  (ev_done),
    .thr_full_o (thr_full),
    .thr_data_o (thr_data),
    .saddr_o    (saddr),
    .locked_o   (locked),
    .stat_o     (stat),
    .irq_o      (irq_o)
  );

  i2c_wm_engine #(.DATA_W(DATA_W), .QTR_DIV(QTR_DIV)) u_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .thr_full_i(thr_full),
    .thr_data_i(thr_data),
    .saddr_i   (saddr),
    .locked_i  (locked),
    .sda_i     (sda_i),
    .ev_start_o(ev_start),
    .ev_load_o (ev_load),
    .ev_nack_o (ev_nack),
    .ev_done_o (ev_done),
    .scl_low_o (scl_oe_o),
    .sda_low_o (sda_oe_o)
  );

  assign stat_o    = stat;
  assign dma_req_o = stat[STAT_TXRDY];

  p_dma_follows_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_THR && dma_req_o) |=> !dma_req_o);
endmodule

// File: tb/i2c_txlock_master_test.sv
module i2c_txlock_master_test;
  localparam int QTR = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       we, rd;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [2:0] stat;
  logic       dma, irq, scl_oe, sda_oe, slv_drv;
  logic       scl_ln, sda_ln;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign scl_ln = !scl_oe;
  assign sda_ln = !(sda_oe | slv_drv);

  i2c_txlock_master #(.DATA_W(8), .QTR_DIV(QTR)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .stat_rd_i(rd), .stat_o(stat), .dma_req_o(dma), .irq_o(irq),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .sda_i(sda_ln)
  );

  // target model: logs every byte, NACKs address bytes while addr_seen < nack_upto
  logic [7:0] rx_byte [0:127];
  logic       rx_ack  [0:127];
  int rx_n = 0, starts = 0, stops = 0, addr_seen = 0, nack_upto = 0;
  int per_min = 1000000, per_max = 0, last_rise = 0;
  logic scl_p = 1'b1, sda_p = 1'b1, rise_ok = 1'b0;
  int cnt = 0, bif = 0;
  logic in_ack = 1'b0, ackv = 1'b0;
  logic [7:0] sh = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      slv_drv <= 1'b0;
      scl_p   <= 1'b1;
      sda_p   <= 1'b1;
      cnt = 0; bif = 0; in_ack = 1'b0;
    end else begin
      scl_p <= scl_ln;
      sda_p <= sda_ln;
      if (scl_ln && scl_p && sda_p && !sda_ln) begin
        starts <= starts + 1;
        cnt = 0; bif = 0; in_ack = 1'b0;
        rise_ok <= 1'b0;
        slv_drv <= 1'b0;
      end else if (scl_ln && scl_p && !sda_p && sda_ln) begin
        stops   <= stops + 1;
        rise_ok <= 1'b0;
      end else if (scl_ln && !scl_p) begin
        if (rise_ok) begin
          if (cyc - last_rise < per_min) per_min <= cyc - last_rise;
          if (cyc - last_rise > per_max) per_max <= cyc - last_rise;
        end
        last_rise <= cyc;
        rise_ok   <= 1'b1;
        if (!in_ack) begin
          sh = {sh[6:0], sda_ln};
          cnt = cnt + 1;
        end
      end else if (!scl_ln && scl_p) begin
        if (in_ack) begin
          in_ack = 1'b0;
          slv_drv <= 1'b0;
        end else if (cnt == 8) begin
          in_ack = 1'b1;
          cnt = 0;
          ackv = !((bif == 0) && (addr_seen < nack_upto));
          rx_byte[rx_n] <= sh;
          rx_ack[rx_n]  <= ackv;
          rx_n <= rx_n + 1;
          if (bif == 0) addr_seen <= addr_seen + 1;
          bif = bif + 1;
          slv_drv <= ackv;
        end
      end
    end
  end

  function automatic logic [7:0] addr_byte(input logic [6:0] a);
    return {a, 1'b0};
  endfunction

  function automatic logic exp_irq(input logic [2:0] s, input logic [2:0] m);
    return |(s & m);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_stat();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_bit(input int idx, input logic val, input string req);
    int n = 0;
    while (stat[idx] !== val && n < 5000) begin @(negedge clk); n++; end
    chk(req, stat[idx], val);
  endtask

  task automatic wait_stops(input int target, input string req);
    int n = 0;
    while (stops < target && n < 20000) begin @(negedge clk); n++; end
    chk(req, stops >= target, 1);
    repeat (2 * QTR + 4) @(negedge clk);
  endtask

  logic [7:0] tx [0:7];

  // streams n bytes from tx[] into one frame, pacing writes on dma_req
  task automatic stream(input int n, input string req);
    int sp = stops;
    wr(2'd2, tx[0]);
    for (int i = 1; i < n; i++) begin
      int w = 0;
      while (!dma && w < 5000) begin @(negedge clk); w++; end
      wr(2'd2, tx[i]);
    end
    wait_stops(sp + 1, req);
  endtask

  task automatic chk_frame(input int base, input logic [6:0] sa, input int n, input string req);
    chk(req, rx_n - base, n + 1);
    chk(req, rx_byte[base], addr_byte(sa));
    for (int i = 0; i < n; i++) chk(req, rx_byte[base + 1 + i], tx[i]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

  initial begin
    int b_rx, b_st, b_sp;
    logic [6:0] sa;
    int n;
    void'($urandom(32'd8121));
    rst_n = 1'b0; we = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1 status", stat, 3'b011);
    chk("R1 dma_req", dma, 1);
    chk("R1 irq", irq, 0);
    chk("R1 lines", {scl_oe, sda_oe}, 0);

    // R2, R3, R5: single byte frame
    wr(2'd1, 8'h50);
    b_rx = rx_n; b_st = starts; b_sp = stops;
    wr(2'd2, 8'hA5);
    chk("R3 dma_req low when full", dma, 0);
    repeat (3) @(negedge clk);
    chk("R5 txcomp cleared at start", stat[1], 0);
    wait_bit(0, 1'b1, "R3 txrdy after load");
    chk("R3 load before stop", stops - b_sp, 0);
    wait_stops(b_sp + 1, "R2 frame ends");
    chk("R5 txcomp after stop", stat[1], 1);
    tx[0] = 8'hA5;
    chk_frame(b_rx, 7'h50, 1, "R2 bytes");
    chk("R2 one start", starts - b_st, 1);

    // R4: streamed bytes share one frame
    b_rx = rx_n; b_st = starts;
    for (int i = 0; i < 5; i++) tx[i] = 8'(8'h3C + 8'(i * 37));
    stream(5, "R4 stream end");
    chk_frame(b_rx, 7'h50, 5, "R4 stream bytes");
    chk("R4 stream one frame", starts - b_st, 1);

    // R4: empty holding register ends the frame, next byte opens a new one
    b_rx = rx_n; b_st = starts;
    tx[0] = 8'h81; stream(1, "R4 gap first");
    tx[0] = 8'h7E; stream(1, "R4 gap second");
    chk("R4 two frames", starts - b_st, 2);
    chk("R4 gap second byte", rx_byte[b_rx + 3], 8'h7E);

    // R6, R7: NACK without lock, DMA-style refill produces a second frame
    b_rx = rx_n; b_st = starts; b_sp = stops;
    nack_upto = addr_seen + 2;
    wr(2'd2, 8'h11);
    wait_bit(2, 1'b1, "R6 nack seen");
    chk("R6 flags together", stat, 3'b111);
    wr(2'd2, 8'h22);
    wait_stops(b_sp + 2, "R7 retry frame ends");
    chk("R7 unlocked retry started", starts - b_st, 2);
    chk("R6 held data discarded", rx_n - b_rx, 2);
    chk("R6 first addr nacked", rx_ack[b_rx], 0);
    chk("R6 second addr nacked", rx_ack[b_rx + 1], 0);
    repeat (200) @(negedge clk);
    chk("R6 no further frame", starts - b_st, 2);
    chk("R6 nack sticky", stat, 3'b111);

    // R10, R9: interrupt masking and stale NACK
    wr(2'd3, 8'h04);
    chk("R10 nack irq", irq, exp_irq(stat, 3'b100));
    chk("R10 nack irq set", irq, 1);
    wr(2'd3, 8'h00);
    rd_stat();
    chk("R9 read clears nack", stat, 3'b011);
    wr(2'd3, 8'h04);
    chk("R9 stale nack silent", irq, 0);
    wr(2'd3, 8'h01);
    chk("R10 txrdy irq", irq, exp_irq(stat, 3'b001));
    wr(2'd3, 8'h02);
    chk("R10 txcomp irq", irq, 1);
    wr(2'd3, 8'h00);
    chk("R10 masked", irq, 0);

    // R8: lock mode holds the refill until lock clear
    wr(2'd0, 8'h01);
    b_rx = rx_n; b_st = starts; b_sp = stops;
    nack_upto = addr_seen + 1;
    wr(2'd2, 8'h33);
    wait_bit(2, 1'b1, "R8 nack seen");
    chk("R6 flags together locked", stat, 3'b111);
    wr(2'd2, 8'h44);
    wait_stops(b_sp + 1, "R8 nack frame ends");
    repeat (300) @(negedge clk);
    chk("R8 no start while locked", starts - b_st, 1);
    chk("R8 byte held", stat, 3'b110);
    chk("R8 lines released", {scl_oe, sda_oe}, 0);
    wr(2'd0, 8'h03);
    wait_stops(b_sp + 2, "R8 frame after clear");
    chk("R8 released frame", starts - b_st, 2);
    chk("R8 held byte sent", rx_byte[b_rx + 2], 8'h44);
    chk("R8 held byte acked", rx_ack[b_rx + 2], 1);
    chk("R8 byte count", rx_n - b_rx, 3);
    wr(2'd0, 8'h00);
    rd_stat();

    // random frames
    for (int k = 0; k < 6; k++) begin
      sa = 7'($urandom);
      n  = 1 + int'($urandom % 4);
      for (int i = 0; i < n; i++) tx[i] = 8'($urandom);
      wr(2'd1, {1'b0, sa});
      b_rx = rx_n; b_st = starts;
      stream(n, "R2 random end");
      chk_frame(b_rx, sa, n, "R2 random bytes");
      chk("R4 random one frame", starts - b_st, 1);
    end
    chk("R5 idle status", stat, 3'b011);

    chk("R11 scl period min", per_min, 4 * QTR);
    chk("R11 scl period max", per_max, 4 * QTR);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule